// File: doc/BRIEF.md
# Multi-Channel Coincidence Bit Decider

This block turns the pulse streams of several photon-counting channels into one recovered data bit per bit period. Each channel carries short digital pulses from its quench controller. Inside the block every channel is brought into the local clock domain and edge-detected. Each detected rising edge sets that channel's own sticky flag. The flags are evaluated and cleared together once per bit period.

The bit period is a programmable count of clock cycles. At the last cycle of each period the block counts the set flags and compares the count with a vote threshold. A threshold of zero asks for every channel to have fired. The result is registered together with a one-cycle valid strobe, so each decision appears one bit period after the light that produced it. The live flag states and the vote count of the last decision are also visible. An edge detected in the boundary cycle itself belongs to the period that starts there.

Top module: `coinc_latch_detector`

## Requirements
- R1: A channel's flag is set only by a rising edge of that channel's input after synchronization; an input that stays high sets it once, at the period in which it rose, and never again while it stays high.
- R2: A set flag stays set until the end of the current bit period; at the period boundary all flags are cleared, except those set by an edge detected in the boundary cycle.
- R3: With a threshold of 0 the decision is 1 exactly when all channel flags were set during the period, and 0 otherwise.
- R4: With a threshold k from 1 to the channel count, the decision is 1 when at least k flags were set; a threshold above the channel count behaves like 0 (all channels).
- R5: `valid_o` is high for exactly one cycle per bit period, in the cycle after the boundary, together with the decision for the period that just ended; `data_o` and `vote_cnt_o` hold their values between strobes.
- R6: Strobes on `valid_o` are `period_len_i` cycles apart; a length of 0 or 1 acts as 2.
- R7: A rising edge detected in the boundary cycle counts toward the new period, not the one being decided.
- R8: `vote_cnt_o` equals the number of flags that were set when the period was decided.
- R9: While `rst_n` is low, `data_o`, `valid_o`, `latch_o` and `vote_cnt_o` are all zero.
- R10: `latch_o` shows the live flags: an input level first sampled high at one clock edge appears on its bit two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_pulse_i | input | NUM_CH | Raw pulse input of each channel |
| period_len_i | input | PERIOD_W | Bit period length in clock cycles |
| vote_thresh_i | input | CNT_W | Required number of fired channels, 0 meaning all |
| data_o | output | 1 | Recovered data bit of the last period |
| valid_o | output | 1 | One-cycle strobe for a new decision |
| latch_o | output | NUM_CH | Live per-channel flags |
| vote_cnt_o | output | CNT_W | Count of fired channels in the last period |

## Verification
On every cycle the assertions check that a detected edge never lasts two cycles, that a flag cannot appear without an edge and cannot drop inside a period, that boundaries are never adjacent, and that the decision holds between strobes and needs at least one vote. Only the bench scenarios show the decision rule itself for each threshold, the one-period lag, the exact strobe spacing including the clamp of short lengths, and the assignment of an edge in the boundary cycle to the following period. Held-high inputs, thresholds above the channel count and random channel patterns with changing period lengths are driven in the bench against expected values computed from the requirements.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  // Decision rule chosen from the threshold input.
  typedef enum logic {
    RULE_ALL     = 1'b0,
    RULE_ATLEAST = 1'b1
  } vote_rule_e;

  // Smallest legal bit period in cycles.
  localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/coinc_edge_sync.sv
module coinc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pulse_i};
    prev_d = sync_q[STAGES-1];
    rise_o = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R1: a detected edge is a single-cycle event
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/coinc_period_timer.sv
module coinc_period_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] len_i,
  output logic                tick_o
);
  import coinc_pkg::*;

  localparam logic [PERIOD_W-1:0] LEN_FLOOR = PERIOD_W'(MIN_PERIOD);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] eff_len;
  logic                cnt_en;

  always_comb begin
    eff_len = (len_i < LEN_FLOOR) ? LEN_FLOOR : len_i;
    tick_o  = (cnt_q >= (eff_len - PERIOD_W'(1)));
    cnt_en  = 1'b1;
    cnt_d   = tick_o ? '0 : (cnt_q + PERIOD_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: two boundaries are never adjacent (shortest period is two cycles)
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/coinc_latch_bank.sv
module coinc_latch_bank #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rise_i,
  input  logic              tick_i,
  output logic [NUM_CH-1:0] latch_o
);

  logic [NUM_CH-1:0] latch_q, latch_d;

  // An edge in the boundary cycle starts the new period's flag (R7).
  always_comb begin
    latch_d = tick_i ? rise_i : (latch_q | rise_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
    end
  end

  assign latch_o = latch_q;

  // R2: inside a period no flag is ever dropped
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R1: a flag only appears after an edge on its own channel
      assert_latch_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_q[g] && !rise_i[g]) |=> !latch_q[g]);
    end
  endgenerate

endmodule

// File: rtl/coinc_vote_decider.sv
module coinc_vote_decider #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] latch_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              data_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  import coinc_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CH);

  vote_rule_e       rule;
  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] need;
  logic             meet;
  logic             data_q, data_d;
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ones = ones + CNT_W'(latch_i[i]);
    end
    rule = ((thresh_i == '0) || (thresh_i > FULL)) ? RULE_ALL : RULE_ATLEAST;
    need = (rule == RULE_ALL) ? FULL : thresh_i;
    meet = (ones >= need);
  end

  always_comb begin
    valid_d = tick_i;
    data_d  = tick_i ? meet : data_q;
    cnt_d   = tick_i ? ones : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;

  // R5: the decision only moves together with a strobe
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(data_q) && $stable(cnt_q)));

  // R3: a positive decision needs at least one fired channel
  assert_one_needs_vote_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && data_q) |-> (cnt_q != '0));

endmodule

// File: rtl/coinc_latch_detector.sv
module coinc_latch_detector #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned PERIOD_W    = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(NUM_CH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_pulse_i,
  input  logic [PERIOD_W-1:0] period_len_i,
  input  logic [CNT_W-1:0]    vote_thresh_i,
  output logic                data_o,
  output logic                valid_o,
  output logic [NUM_CH-1:0]   latch_o,
  output logic [CNT_W-1:0]    vote_cnt_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_CH-1:0] rise;
  logic              tick;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      coinc_edge_sync #(
        .STAGES (SYNC_STAGES)
      ) u_sync (
        .clk     (clk),
        .rst_n   (rst_sync_q),
        .pulse_i (ch_pulse_i[c]),
        .rise_o  (rise[c])
      );
    end
  endgenerate

  coinc_period_timer #(
    .PERIOD_W (PERIOD_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .len_i  (period_len_i),
    .tick_o (tick)
  );

  coinc_latch_bank #(
    .NUM_CH (NUM_CH)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rise_i  (rise),
    .tick_i  (tick),
    .latch_o (latch_o)
  );

  coinc_vote_decider #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
  ) u_vote (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .latch_i  (latch_o),
    .tick_i   (tick),
    .thresh_i (vote_thresh_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .cnt_o    (vote_cnt_o)
  );

  // R5: the decision strobe never lasts more than one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_o |=> !valid_o);

  // R8: the reported vote never exceeds the channel count
  assert_vote_bound_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_o |-> (vote_cnt_o <= CNT_W'(NUM_CH)));

endmodule

// File: tb/tb_coinc_latch_detector.sv
module tb_coinc_latch_detector;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int PW         = 16;
  localparam int CW         = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NCH-1:0] ch_pulse;
  logic [PW-1:0] period_len;
  logic [CW-1:0] vote_thresh;
  logic          data_o, valid_o;
  logic [NCH-1:0] latch_o;
  logic [CW-1:0] vote_cnt_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [NCH-1:0] prev_lvl  = '0;
  logic [NCH-1:0] last_late = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coinc_latch_detector dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_pulse_i    (ch_pulse),
    .period_len_i  (period_len),
    .vote_thresh_i (vote_thresh),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .latch_o       (latch_o),
    .vote_cnt_o    (vote_cnt_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic bit exp_decide(input int cnt, input int thr);
    int eff;
    eff = (thr == 0 || thr > NCH) ? NCH : thr;
    return cnt >= eff;
  endfunction

  // Called at the falling edge right after a boundary (valid_o high).
  task automatic run_period(input logic [NCH-1:0] pmask, input logic [NCH-1:0] hold,
                            input logic [NCH-1:0] late, input int len, input int thr,
                            input string tag);
    int off[NCH];
    int wid[NCH];
    logic [NCH-1:0] exp_latch;
    logic [NCH-1:0] drv;
    int cnt;
    bit exp_d;
    period_len  = PW'(len);
    vote_thresh = CW'(thr);
    exp_latch   = pmask | last_late | (hold & ~prev_lvl);
    for (int c = 0; c < NCH; c++) begin
      off[c] = $urandom_range(0, len - 7);
      wid[c] = $urandom_range(1, 2);
    end
    for (int k = 0; k < len; k++) begin
      if (k == 1)
        chk(valid_o == 1'b0, {"R5 strobe one cycle ", tag}, valid_o, 0);
      if (k == len - 2)
        chk(latch_o == exp_latch, {"R10 R2 live flags ", tag}, latch_o, exp_latch);
      drv = hold;
      for (int c = 0; c < NCH; c++)
        if (pmask[c] && k >= off[c] && k < off[c] + wid[c]) drv[c] = 1'b1;
      if (k == len - 3) drv = drv | late;
      ch_pulse = drv;
      @(negedge clk);
    end
    prev_lvl  = hold;
    last_late = late;
    cnt   = $countones(exp_latch);
    exp_d = exp_decide(cnt, thr);
    chk(valid_o == 1'b1, {"R5 R6 strobe at period end ", tag}, valid_o, 1);
    chk(data_o == exp_d, {"decision ", tag}, data_o, exp_d);
    chk(vote_cnt_o == CW'(cnt), {"R8 vote count ", tag}, vote_cnt_o, cnt);
    chk(latch_o == late, {"R2 R7 flags after boundary ", tag}, latch_o, late);
  endtask

  task automatic measure_len(input int len, input int expn, input string tag);
    int n;
    period_len = PW'(len);
    ch_pulse   = '0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!valid_o && n < 100);
    chk(n == expn, tag, n, expn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int waitn;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    ch_pulse = '0;
    period_len = PW'(10);
    vote_thresh = '0;
    repeat (3) @(negedge clk);
    chk(data_o == 1'b0, "R9 reset data", data_o, 0);
    chk(valid_o == 1'b0, "R9 reset valid", valid_o, 0);
    chk(latch_o == '0, "R9 reset flags", latch_o, 0);
    chk(vote_cnt_o == '0, "R9 reset count", vote_cnt_o, 0);
    rst_n = 1'b1;
    waitn = 0;
    while (!valid_o && waitn < 100) begin
      @(negedge clk);
      waitn++;
    end
    chk(valid_o == 1'b1, "R6 first strobe after reset", valid_o, 1);

    // R3: all-channel rule
    run_period(4'hF, 4'h0, 4'h0, 10, 0, "R3 all fired");
    run_period(4'h7, 4'h0, 4'h0, 10, 0, "R3 one missing");
    run_period(4'h0, 4'h0, 4'h0, 10, 0, "R3 none fired");
    // R4: at-least rule and out-of-range threshold
    run_period(4'h7, 4'h0, 4'h0, 10, 3, "R4 three of three");
    run_period(4'h7, 4'h0, 4'h0, 10, 4, "R4 three of four");
    run_period(4'h4, 4'h0, 4'h0, 10, 1, "R4 one of one");
    run_period(4'hF, 4'h0, 4'h0, 10, 5, "R4 above count all fired");
    run_period(4'hE, 4'h0, 4'h0, 10, 6, "R4 above count one missing");
    // R1: a held level counts only once
    run_period(4'hE, 4'h1, 4'h0, 12, 0, "R1 rising level");
    run_period(4'hE, 4'h1, 4'h0, 12, 0, "R1 held level");
    run_period(4'hE, 4'h0, 4'h0, 12, 0, "R1 falling level");
    // R7: edge in the boundary cycle moves to the next period
    run_period(4'hF, 4'h0, 4'h2, 10, 0, "R7 boundary edge");
    run_period(4'hD, 4'h0, 4'h0, 10, 0, "R7 carried flag");
    run_period(4'h1, 4'h0, 4'h8, 10, 0, "R7 late only");
    run_period(4'h7, 4'h0, 4'h0, 10, 0, "R7 late completes");
    // R6: clamp of short lengths and plain spacing
    measure_len(1, 2, "R6 length one acts as two");
    measure_len(0, 2, "R6 length zero acts as two");
    measure_len(13, 13, "R6 length thirteen");

    // Random patterns
    for (int p = 0; p < 60; p++) begin
      int len;
      int thr;
      logic [NCH-1:0] pm;
      logic [NCH-1:0] lt;
      len = $urandom_range(8, 20);
      thr = $urandom_range(0, 5);
      pm  = NCH'($urandom_range(0, 15));
      lt  = ($urandom_range(0, 3) == 0) ? NCH'($urandom_range(0, 15)) : '0;
      run_period(pm, 4'h0, lt, len, thr, "R3 R4 random");
    end
    run_period(4'h0, 4'h0, 4'h0, 10, 0, "R2 drain");
    finish_run();
  end

endmodule